// File: doc/BRIEF.md
# Serial Stream Time-Slot Interchange Switch

The block is a non-blocking switch for eight serial time-division streams. A frame has 32 eight-bit channels on each stream, so 256 bit periods per frame. In this RTL one clock cycle is one bit period. Every received channel is stored in a data memory that has one bank for each frame parity. For each of the 256 output slots (stream, channel), a connection memory decides what the slot carries. It is either the stored byte of a chosen source stream and channel, or a fixed message byte. It also sets whether the slot is driven at all.

The connection memory has two parts for each slot. The low byte holds the source address or the message byte. The high byte holds three flags: slot drive enable, message mode, and constant delay. A small write-only register port loads both parts and a one-bit global message control. The block gives each output as a data bit plus a drive enable, so that a pad ring can build tri-state outputs. An output-disable input overrides every enable. This lets several switches share output wires.

Top module: `tsi_switch`

## Requirements
- R1: A high `frame_sync` marks the first bit period of channel 0. Each channel lasts 8 cycles and is sent and received most significant bit first. After channel 31 the frame restarts at channel 0 without any new sync.
- R2: For a slot in connection mode, low-byte bits [7:5] give the source stream and bits [4:0] give the source channel. The slot carries that source's stored byte.
- R3: With high-byte bit 6 = 0 (variable delay), output channel c of frame F takes the source byte from frame F when c ≥ 1 and the source channel is less than c. In every other case it takes the byte from frame F−1.
- R4: With high-byte bit 6 = 1 (constant delay), a slot in frame F always takes the source byte received in frame F−1.
- R5: With high-byte bit 2 = 1, the slot transmits its own low byte instead of switched data.
- R6: A control write (`cfg_sel` = 2) with data bit 6 = 1 puts every slot in message mode. Writing bit 6 = 0 restores the per-slot choice.
- R7: High-byte bit 0 = 1 raises `ser_drive` for the whole 8-cycle slot. Bit 0 = 0 keeps that slot undriven.
- R8: While `odis_n` is low, every `ser_drive` bit is 0 in the same cycle, whatever the memory contents.
- R9: Register writes use `cfg_sel` = 0 for the low byte and 1 for the high byte, with `cfg_addr` = stream·32 + channel. A write affects a slot only if it is presented before that slot's loading cycle, which is the last bit cycle of the preceding channel. A write presented in that loading cycle counts for the next frame's slot. A write never changes a slot already being sent.
- R10: Reset clears every high byte and the control bit. Outputs are undriven until they are programmed.
- R11: A `frame_sync` in the middle of a frame restarts counting at channel 0. Slots from channel 1 onward follow the new alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-period clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | High in the first bit period of a frame |
| ser_in | input | 8 | Serial input bit for each stream |
| odis_n | input | 1 | Low forces all outputs undriven |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 0 low byte, 1 high byte, 2 control |
| cfg_addr | input | 8 | Slot index, stream·32 + channel |
| cfg_wdata | input | 8 | Write data |
| ser_out | output | 8 | Serial output bit for each stream |
| ser_drive | output | 8 | Drive enable for each output stream |

## Verification
The hardest cases to reach are the delay boundaries. One is a source channel that finishes arriving in the same cycle as the load for the next output channel. The other is a channel-0 slot that is loaded before its own frame starts. Directed connections cover both: source channel 31 to output channel 0 in both delay modes, and a source channel one below its output channel. Register writes placed exactly in a loading cycle cover the write-timing rule. Random connections, random mid-run rewrites and random output-disable pulses run against a bench model that keeps the current and previous input frames.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    parameter int NSTR = 8;
    parameter int NCH  = 32;
    parameter int WB   = 8;

    localparam int SW    = $clog2(NSTR);
    localparam int CW    = $clog2(NCH);
    localparam int BW    = $clog2(WB);
    localparam int IW    = SW + CW;
    localparam int PW    = CW + BW;
    localparam int NSLOT = NSTR * NCH;

    // flag positions in the high byte and the control byte
    localparam int HI_EN    = 0;
    localparam int HI_MSG   = 2;
    localparam int HI_CONST = 6;
    localparam int CTL_MSG  = 6;

    typedef enum logic [1:0] {
        CFG_LOW  = 2'd0,
        CFG_HIGH = 2'd1,
        CFG_CTRL = 2'd2,
        CFG_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [CW-1:0] chan;
        logic [BW-1:0] bitn;
    } pos_t;

    typedef struct packed {
        logic [SW-1:0] strm;
        logic [CW-1:0] chan;
    } src_t;

    typedef struct packed {
        logic konst;
        logic msg;
        logic en;
    } attr_t;

    function automatic attr_t attr_of(input logic [WB-1:0] b);
        attr_t a;
        a.konst = b[HI_CONST];
        a.msg   = b[HI_MSG];
        a.en    = b[HI_EN];
        return a;
    endfunction

    function automatic src_t src_of(input logic [WB-1:0] b);
        return src_t'(b);
    endfunction
endpackage

// File: rtl/tsi_timebase.sv
module tsi_timebase
    import tsi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_sync,
    output pos_t pos,
    output logic par,
    output logic last_bit
);
    pos_t cnt_q;
    logic par_q;

    always_comb begin
        pos      = frame_sync ? '0 : cnt_q;
        // an early sync starts a new frame, so the bank flips with it
        par      = par_q ^ (frame_sync && (cnt_q != '0));
        last_bit = (pos.bitn == BW'(WB - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            par_q <= 1'b0;
        end else begin
            cnt_q <= pos_t'(PW'(pos) + PW'(1));
            par_q <= par ^ (pos == '1);
        end
    end
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem
    import tsi_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  cfg_sel_e       sel,
    input  logic [IW-1:0]  addr,
    input  logic [WB-1:0]  wdata,
    input  logic [IW-1:0]  rd_idx  [NSTR],
    output logic [WB-1:0]  rd_lo   [NSTR],
    output attr_t          rd_attr [NSTR],
    output logic           gmsg
);
    logic [WB-1:0] lo_mem [NSLOT];
    attr_t         at_mem [NSLOT];
    logic          gmsg_q;

    always_ff @(posedge clk) begin
        if (we && sel == CFG_LOW) lo_mem[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOT; i++) at_mem[i] <= '0;
        end else if (we && sel == CFG_HIGH) begin
            at_mem[addr] <= attr_of(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                          gmsg_q <= 1'b0;
        else if (we && sel == CFG_CTRL)   gmsg_q <= wdata[CTL_MSG];
    end

    assign gmsg = gmsg_q;

    for (genvar s = 0; s < NSTR; s++) begin : g_rd
        assign rd_lo[s]   = lo_mem[rd_idx[s]];
        assign rd_attr[s] = at_mem[rd_idx[s]];
    end
endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem
    import tsi_pkg::*;
(
    input  logic            clk,
    input  logic [NSTR-1:0] ser_in,
    input  logic [CW-1:0]   cur_ch,
    input  logic            par,
    input  logic            last_bit,
    input  logic            rd_bank [NSTR],
    input  src_t            rd_src  [NSTR],
    output logic [WB-1:0]   rd_data [NSTR]
);
    logic [WB-2:0] sh_q   [NSTR];
    logic [WB-1:0] done_b [NSTR];
    logic [WB-1:0] mem    [2][NSLOT];

    for (genvar s = 0; s < NSTR; s++) begin : g_rx
        assign done_b[s] = {sh_q[s], ser_in[s]};
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < NSTR; s++) begin
            sh_q[s] <= done_b[s][WB-2:0];
            if (last_bit) mem[par][{SW'(s), cur_ch}] <= done_b[s];
        end
    end

    // a byte completing in this very cycle is forwarded to the reader
    for (genvar s = 0; s < NSTR; s++) begin : g_rdp
        logic byp;
        assign byp = last_bit && (rd_bank[s] == par) && (rd_src[s].chan == cur_ch);
        assign rd_data[s] = byp ? done_b[rd_src[s].strm] : mem[rd_bank[s]][rd_src[s]];
    end
endmodule

// File: rtl/tsi_lane.sv
module tsi_lane
    import tsi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] cur_ch,
    input  logic [CW-1:0] nxt_ch,
    input  logic          par,
    input  logic [WB-1:0] lo,
    input  attr_t         attr,
    input  logic          gmsg,
    input  logic [WB-1:0] src_data,
    input  logic          odis_n,
    output logic          rd_bank,
    output logic          ser_bit,
    output logic          drive
);
    logic [WB-1:0] sh_q;
    logic          en_q;
    logic          out_par;

    always_comb begin
        // channel 0 is fetched at the end of the previous frame
        out_par = (nxt_ch == '0) ? ~par : par;
        if (attr.konst)               rd_bank = ~out_par;
        else if (lo[CW-1:0] <= cur_ch) rd_bank = par;
        else                          rd_bank = ~par;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            en_q <= 1'b0;
        end else if (load) begin
            sh_q <= (attr.msg || gmsg) ? lo : src_data;
            en_q <= attr.en;
        end else begin
            sh_q <= {sh_q[WB-2:0], 1'b0};
        end
    end

    assign ser_bit = sh_q[WB-1];
    assign drive   = en_q & odis_n;
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_sync,
    input  logic [NSTR-1:0] ser_in,
    input  logic            odis_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [IW-1:0]   cfg_addr,
    input  logic [WB-1:0]   cfg_wdata,
    output logic [NSTR-1:0] ser_out,
    output logic [NSTR-1:0] ser_drive
);
    pos_t          pos;
    logic          par;
    logic          last_bit;
    logic [CW-1:0] nxt_ch;
    logic          gmsg;
    logic [IW-1:0] rd_idx  [NSTR];
    logic [WB-1:0] lo      [NSTR];
    attr_t         attr    [NSTR];
    logic          bank    [NSTR];
    src_t          src     [NSTR];
    logic [WB-1:0] sdata   [NSTR];

    assign nxt_ch = pos.chan + CW'(1);

    tsi_timebase u_tb (
        .clk(clk), .rst(rst), .frame_sync(frame_sync),
        .pos(pos), .par(par), .last_bit(last_bit)
    );

    tsi_cmem u_cm (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel_e'(cfg_sel)),
        .addr(cfg_addr), .wdata(cfg_wdata), .rd_idx(rd_idx),
        .rd_lo(lo), .rd_attr(attr), .gmsg(gmsg)
    );

    tsi_dmem u_dm (
        .clk(clk), .ser_in(ser_in), .cur_ch(pos.chan), .par(par),
        .last_bit(last_bit), .rd_bank(bank), .rd_src(src), .rd_data(sdata)
    );

    for (genvar s = 0; s < NSTR; s++) begin : g_lane
        assign rd_idx[s] = {SW'(s), nxt_ch};
        assign src[s]    = src_of(lo[s]);

        tsi_lane u_ln (
            .clk(clk), .rst(rst), .load(last_bit), .cur_ch(pos.chan),
            .nxt_ch(nxt_ch), .par(par), .lo(lo[s]), .attr(attr[s]),
            .gmsg(gmsg), .src_data(sdata[s]), .odis_n(odis_n),
            .rd_bank(bank[s]), .ser_bit(ser_out[s]), .drive(ser_drive[s])
        );
    end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
    import tsi_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            frame_sync,
    input logic            odis_n,
    input logic [NSTR-1:0] ser_drive,
    input logic [PW-1:0]   pos_v
);
    AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
        !frame_sync |=> (frame_sync || pos_v == PW'($past(pos_v) + PW'(1)))); // R1

    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> (frame_sync || pos_v == PW'(1))); // R11

    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !odis_n |-> (ser_drive == '0)); // R8

    AST_DRIVE_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pos_v[BW-1:0] != '0 && $stable(odis_n)) |-> $stable(ser_drive)); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (ser_drive == '0)); // R10
endmodule

bind tsi_switch tsi_switch_chk u_chk (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .odis_n(odis_n),
    .ser_drive(ser_drive), .pos_v(pos)
);

// File: tb/tsi_switch_test.sv
module tsi_switch_test;
    import tsi_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_sync = 1'b0;
    logic [7:0] ser_in = '0;
    logic       odis_n = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] ser_out;
    logic [7:0] ser_drive;

    always #5 clk = ~clk;

    tsi_switch uut (
        .clk(clk), .rst(rst), .frame_sync(frame_sync), .ser_in(ser_in),
        .odis_n(odis_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ser_out(ser_out), .ser_drive(ser_drive)
    );

    int total = 0, bad = 0;
    int p = 0, fr = 0;
    bit synced = 0, data_ok = 0, resync_tag = 0, done = 0;
    logic [7:0] cur_in [8][32];
    logic [7:0] prev_in [8][32];
    logic [7:0] m_lo [256];
    bit m_en [256], m_msg [256], m_konst [256];
    bit m_gmsg = 0;
    logic [7:0] e_byte [8];
    bit e_en [8], e_valid [8];
    string e_tag [8];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s p=%0d frame=%0d actual=%0d expected=%0d", tag, p, fr, act, exp);
        end
    endtask

    task automatic gen_frame();
        for (int s = 0; s < 8; s++)
            for (int c = 0; c < 32; c++) cur_in[s][c] = 8'($urandom);
    endtask

    // bench model of one slot load, taken before this cycle's write lands (R9)
    task automatic snapshot(input int cn, input bit we, input logic [1:0] sel, input int addr);
        for (int s = 0; s < 8; s++) begin
            int idx = s * 32 + cn;
            int ss = int'(m_lo[idx][7:5]);
            int sc = int'(m_lo[idx][4:0]);
            e_en[s] = m_en[idx];
            if (m_msg[idx] || m_gmsg) begin
                e_byte[s]  = m_lo[idx];
                e_valid[s] = 1;
                e_tag[s]   = m_gmsg ? "R6 global message" : "R5 slot message";
            end else begin
                if (m_konst[idx]) begin
                    e_byte[s] = (cn == 0) ? cur_in[ss][sc] : prev_in[ss][sc];
                    e_tag[s]  = "R4 constant delay (R1 R2)";
                end else begin
                    e_byte[s] = (cn != 0 && sc < cn) ? cur_in[ss][sc] : prev_in[ss][sc];
                    if (cn == 0) e_byte[s] = cur_in[ss][sc];
                    e_tag[s]  = "R3 variable delay (R1 R2)";
                end
                e_valid[s] = data_ok && (cn == 0 || fr >= 1);
            end
            if (resync_tag) e_tag[s] = "R11 realigned slot";
            if (we && sel != 2'd2 && sel != 2'd3 && addr == idx) e_tag[s] = "R9 write in load cycle";
        end
    endtask

    // called at a falling edge; drives one bit period and checks it
    task automatic step(input bit fs, input bit we, input logic [1:0] sel,
                        input int addr, input logic [7:0] wd, input bit odis);
        if (fs) begin
            if (p != 0) begin
                data_ok = 0;
                resync_tag = 1;
                for (int s = 0; s < 8; s++) e_valid[s] = 0;
                p = 0;
            end else if (!synced) begin
                synced = 1; data_ok = 1; fr = 0;
            end
        end
        frame_sync = fs;
        cfg_we = we; cfg_sel = sel; cfg_addr = 8'(addr); cfg_wdata = wd; odis_n = odis;
        for (int s = 0; s < 8; s++) ser_in[s] = cur_in[s][p / 8][7 - (p % 8)];
        #1;
        for (int s = 0; s < 8; s++) begin
            bit ed = e_en[s] & odis;
            check(ser_drive[s] === ed, odis ? "R7 slot drive" : "R8 output disable",
                  int'(ser_drive[s]), int'(ed));
            if (ed && e_valid[s])
                check(ser_out[s] === e_byte[s][7 - (p % 8)], e_tag[s],
                      int'(ser_out[s]), int'(e_byte[s][7 - (p % 8)]));
        end
        if (p % 8 == 7) snapshot(((p / 8) + 1) % 32, we, sel, addr);
        if (we) begin
            case (sel)
                2'd0: m_lo[addr] = wd;
                2'd1: begin m_en[addr] = wd[0]; m_msg[addr] = wd[2]; m_konst[addr] = wd[6]; end
                2'd2: m_gmsg = wd[6];
                default: ;
            endcase
        end
        p = (p + 1) % 256;
        if (p == 0) begin
            prev_in = cur_in;
            gen_frame();
            fr++;
            resync_tag = 0;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n, input bit odis);
        for (int i = 0; i < n; i++) step(p == 0, 0, 2'd0, 0, 8'h00, odis);
    endtask

    task automatic wr(input logic [1:0] sel, input int addr, input logic [7:0] wd);
        step(p == 0, 1, sel, addr, wd, 1);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired (R1 timing)");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd7177));
        for (int i = 0; i < 256; i++) begin
            m_lo[i] = '0; m_en[i] = 0; m_msg[i] = 0; m_konst[i] = 0;
        end
        for (int s = 0; s < 8; s++) begin e_en[s] = 0; e_valid[s] = 0; e_tag[s] = "R10"; end
        gen_frame();
        prev_in = cur_in;

        // R10: nothing driven during and right after reset
        repeat (4) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            check(ser_drive === 8'h00, "R10 reset leaves outputs undriven", int'(ser_drive), 0);
            @(negedge clk);
        end
        rst = 1'b0;

        // R10: unprogrammed slots stay undriven for a while
        idle(16, 1);

        // random program of the whole switch, before the first sync
        for (int i = 0; i < 256; i++) begin
            logic [7:0] h = 8'($urandom) & 8'h45;
            if ($urandom % 8 != 0) h[0] = 1'b1;
            step(0, 1, 2'd0, i, 8'($urandom), 1);
            step(0, 1, 2'd1, i, h, 1);
        end
        while (p != 0) idle(1, 1);

        // random run: R2 R3 R4 R5 R6 R7 R8 R9
        begin
            bit od = 1;
            for (int i = 0; i < 4 * 256; i++) begin
                int r = int'($urandom % 64);
                logic [1:0] sl = (r % 8 == 0) ? 2'd2 : 2'(r % 2);
                if ($urandom % 48 == 0) od = ~od;
                if (r < 4) step(p == 0, 1, sl, int'($urandom % 256), 8'($urandom), od);
                else       step(p == 0, 0, 2'd0, 0, 8'h00, od);
            end
        end

        // directed delay corners
        wr(2'd2, 0, 8'h00);
        wr(2'd0, 0 * 32 + 0, 8'hFF); wr(2'd1, 0 * 32 + 0, 8'h41);   // R4: src ch31 -> ch0 constant
        wr(2'd0, 1 * 32 + 0, 8'hFF); wr(2'd1, 1 * 32 + 0, 8'h01);   // R3: src ch31 -> ch0 variable
        wr(2'd0, 2 * 32 + 5, 8'h64); wr(2'd1, 2 * 32 + 5, 8'h01);   // R3: src ch4 -> ch5 (same-cycle forward)
        wr(2'd0, 3 * 32 + 5, 8'h65); wr(2'd1, 3 * 32 + 5, 8'h01);   // R3: src ch5 -> ch5 (previous frame)
        wr(2'd0, 6 * 32 + 3, 8'hA5); wr(2'd1, 6 * 32 + 3, 8'h05);   // R5
        for (int c = 0; c < 32; c++) begin                          // R2 R4: broadcast one source
            wr(2'd0, 4 * 32 + c, 8'h09);
            wr(2'd1, 4 * 32 + c, 8'h41);
        end
        idle(2 * 256, 1);

        // R9: writes placed exactly in a load cycle, then just before one
        while (p != 9 * 8 + 7) idle(1, 1);
        step(0, 1, 2'd1, 5 * 32 + 10, 8'h00, 1);
        while (p != 20 * 8 + 6) idle(1, 1);
        step(0, 1, 2'd1, 5 * 32 + 21, 8'h00, 1);
        idle(2 * 256, 1);

        // R6 then R11: all message mode, then an early sync
        wr(2'd2, 0, 8'h40);
        for (int i = 0; i < 8; i++) wr(2'd1, i * 32 + 1, 8'h01);
        idle(300, 1);
        while (p != 100) idle(1, 1);
        step(1, 0, 2'd0, 0, 8'h00, 1);
        idle(300, 1);

        done = 1;
        finish_run();
    end
endmodule